// File: doc/BRIEF.md
# Fixed Off-Time Chopper for One Motor Phase

This block regulates the current in one winding of a bipolar stepper motor by switching its H-bridge between three bridge states. While enabled it drives the winding and watches an already synchronized current-trip comparator. When the current reaches the trip level, the bridge leaves the drive state for a programmable, fixed number of clock cycles and then drives again.

The off-time is spent in one of two ways. In slow decay the whole off-time is slow decay. In mixed decay the first 31.25 % of the off-time, computed as `(N*5)>>4`, is fast decay and slow decay fills the rest. The step sequencer selects mixed decay on steps where the phase current falls. A strap input forces mixed decay at all times.

Each turn-on opens a blanking window that masks the trip input, so switching spikes cannot end the drive period early. The comparator, the reference DAC and the gate drivers are outside this block.

Top module: `offtime_chopper`

## Requirements
- R1: After reset, and one cycle after any cycle in which `en` is sampled low, `drive_on`, `fast_on`, `slow_on` and `blank_act` are all 0.
- R2: When `en` is sampled high while idle, `drive_on` and `blank_act` assert on the next cycle. Blanking lasts exactly `BLANK_CYC` cycles, and `trip` has no effect during it.
- R3: After blanking, the block is in the drive state: `drive_on`=1 and `blank_act`=0. If `trip` is high in a drive-state cycle, the off-time starts on the next cycle. A trip held high through blanking therefore starts the off-time after exactly one drive-state cycle.
- R4: In slow decay, the off-time is N cycles of `slow_on` alone, where N is the sampled `off_cycles`. The block then goes back into blanking.
- R5: In mixed decay, the off-time is floor(5N/16) cycles of `fast_on` followed by N−floor(5N/16) cycles of `slow_on`, N cycles in total. When floor(5N/16) is 0, no fast cycle occurs.
- R6: Mixed decay applies when `mix_req`=1 or `auto_mix`=1. Slow decay applies only when both are 0.
- R7: The decay choice and `off_cycles` are sampled in the trip cycle. Changing either during an off-time does not change that off-time.
- R8: An `off_cycles` value of 0 behaves as 1.
- R9: At most one of `drive_on`, `fast_on` and `slow_on` is high, and `blank_act` is high only together with `drive_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables regulation; low forces idle |
| trip | input | 1 | Synchronized current-trip comparator |
| mix_req | input | 1 | Decay request from the sequencer, 1 = mixed |
| auto_mix | input | 1 | Strap, 1 = mixed decay always |
| off_cycles | input | OFF_W | Off-time length N in clock cycles |
| drive_on | output | 1 | Bridge drives the winding |
| fast_on | output | 1 | Bridge in fast decay |
| slow_on | output | 1 | Bridge in slow decay |
| blank_act | output | 1 | Trip input is masked |

## Verification
The bench targets the cycle counts at phase boundaries. A one-off error in the blanking counter would lengthen or shorten the masked window. A wrong split would give 9 or 11 fast cycles for N=32 instead of 10. For N below 4 the fast length is 0, and a design that inserts a fast cycle anyway breaks the total. The bench holds trip high across blanking: a design that samples trip during blanking, or waits an extra cycle afterwards, is caught by the per-cycle model. The bench also changes the mode and the length in the middle of an off-time, and programs N=0. A design that reads the live inputs instead of the values latched at the trip, or one that hangs at zero, would change the measured phase lengths.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BLANK = 3'd1,
    ST_DRIVE = 3'd2,
    ST_FAST  = 3'd3,
    ST_SLOW  = 3'd4
  } chop_state_e;

  typedef struct packed {
    logic drive;
    logic fast;
    logic slow;
    logic blank;
  } bridge_cmd_t;

  function automatic bridge_cmd_t cmd_of(chop_state_e s);
    bridge_cmd_t c;
    c = '0;
    case (s)
      ST_BLANK: begin
        c.drive = 1'b1;
        c.blank = 1'b1;
      end
      ST_DRIVE: c.drive = 1'b1;
      ST_FAST:  c.fast  = 1'b1;
      ST_SLOW:  c.slow  = 1'b1;
      default:  c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/chop_phase_cnt.sv
module chop_phase_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         cnt_zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/chop_decay_split.sv
module chop_decay_split #(
  parameter int W = 10
) (
  input  logic [W-1:0] len_req,
  input  logic         mixed,
  output logic [W-1:0] fast_len,
  output logic [W-1:0] slow_len
);

  localparam int PW = W + 3;

  logic [W-1:0]  n_eff;
  logic [PW-1:0] n_wide;
  logic [PW-1:0] prod;

  always_comb begin
    n_eff    = (len_req == '0) ? W'(1) : len_req;
    n_wide   = {3'b000, n_eff};
    prod     = (n_wide << 2) + n_wide;
    fast_len = mixed ? W'(prod >> 4) : '0;
    slow_len = n_eff - fast_len;
  end

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int W     = 10,
  parameter int BLK_W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         trip,
  input  logic [W-1:0] fast_len,
  input  logic [W-1:0] slow_len,
  input  logic         blank_zero,
  input  logic         off_zero,
  output logic         blank_load,
  output logic         off_load,
  output logic [W-1:0] off_val,
  output bridge_cmd_t  cmd
);

  chop_state_e st_q, st_d;
  logic [W-1:0] slow_hold_q, slow_hold_d;

  always_comb begin
    st_d        = st_q;
    slow_hold_d = slow_hold_q;
    blank_load  = 1'b0;
    off_load    = 1'b0;
    off_val     = '0;
    case (st_q)
      ST_IDLE: begin
        if (en) begin
          st_d       = ST_BLANK;
          blank_load = 1'b1;
        end
      end
      ST_BLANK: begin
        if (!en)            st_d = ST_IDLE;
        else if (blank_zero) st_d = ST_DRIVE;
      end
      ST_DRIVE: begin
        if (!en) begin
          st_d = ST_IDLE;
        end else if (trip) begin
          off_load    = 1'b1;
          slow_hold_d = slow_len;
          if (fast_len != '0) begin
            st_d    = ST_FAST;
            off_val = fast_len - W'(1);
          end else begin
            st_d    = ST_SLOW;
            off_val = slow_len - W'(1);
          end
        end
      end
      ST_FAST: begin
        if (!en) begin
          st_d = ST_IDLE;
        end else if (off_zero) begin
          st_d     = ST_SLOW;
          off_load = 1'b1;
          off_val  = slow_hold_q - W'(1);
        end
      end
      ST_SLOW: begin
        if (!en) begin
          st_d = ST_IDLE;
        end else if (off_zero) begin
          st_d       = ST_BLANK;
          blank_load = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      slow_hold_q <= '0;
      cmd         <= '0;
    end else begin
      st_q        <= st_d;
      slow_hold_q <= slow_hold_d;
      cmd         <= cmd_of(st_d);
    end
  end

endmodule

// File: rtl/offtime_chopper.sv
module offtime_chopper
  import chop_pkg::*;
#(
  parameter int OFF_W     = 10,
  parameter int BLANK_CYC = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             trip,
  input  logic             mix_req,
  input  logic             auto_mix,
  input  logic [OFF_W-1:0] off_cycles,
  output logic             drive_on,
  output logic             fast_on,
  output logic             slow_on,
  output logic             blank_act
);

  localparam int BLK_W = $clog2(BLANK_CYC + 1);
  localparam logic [BLK_W-1:0] BLK_LOAD = BLK_W'(BLANK_CYC - 1);

  logic             mixed_eff;
  logic [OFF_W-1:0] fast_len, slow_len, off_val;
  logic             blank_load, off_load, blank_zero, off_zero;
  bridge_cmd_t      cmd;

  assign mixed_eff = mix_req | auto_mix;

  chop_decay_split #(.W(OFF_W)) u_split (
    .len_req  (off_cycles),
    .mixed    (mixed_eff),
    .fast_len (fast_len),
    .slow_len (slow_len)
  );

  chop_phase_cnt #(.W(BLK_W)) u_blank_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (blank_load),
    .load_val (BLK_LOAD),
    .cnt_zero (blank_zero)
  );

  chop_phase_cnt #(.W(OFF_W)) u_off_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (off_load),
    .load_val (off_val),
    .cnt_zero (off_zero)
  );

  chop_ctrl #(.W(OFF_W), .BLK_W(BLK_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .trip       (trip),
    .fast_len   (fast_len),
    .slow_len   (slow_len),
    .blank_zero (blank_zero),
    .off_zero   (off_zero),
    .blank_load (blank_load),
    .off_load   (off_load),
    .off_val    (off_val),
    .cmd        (cmd)
  );

  assign drive_on  = cmd.drive;
  assign fast_on   = cmd.fast;
  assign slow_on   = cmd.slow;
  assign blank_act = cmd.blank;

endmodule

// File: rtl/offtime_chopper_chk.sv
module offtime_chopper_chk #(
  parameter int BLANK_CYC = 6
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic trip,
  input logic drive_on,
  input logic fast_on,
  input logic slow_on,
  input logic blank_act
);

  localparam int RW = $clog2(BLANK_CYC + 2);
  logic [RW-1:0] blank_run;

  always_ff @(posedge clk) begin
    if (rst)            blank_run <= '0;
    else if (blank_act) blank_run <= blank_run + RW'(1);
    else                blank_run <= '0;
  end

  // R9
  one_bridge_state_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({drive_on, fast_on, slow_on}));

  // R9
  blank_with_drive_chk: assert property (@(posedge clk) disable iff (rst)
    blank_act |-> drive_on);

  // R1
  idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !(drive_on || fast_on || slow_on || blank_act));

  // R2
  turn_on_blanks_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_on) |-> blank_act);

  // R2
  blank_ignores_trip_chk: assert property (@(posedge clk) disable iff (rst)
    (blank_act && en) |=> drive_on);

  // R2
  blank_len_chk: assert property (@(posedge clk) disable iff (rst)
    blank_act |-> (blank_run < RW'(BLANK_CYC)));

  // R3
  trip_ends_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (drive_on && !blank_act && en && trip) |=> (fast_on || slow_on));

  // R5
  fast_then_slow_chk: assert property (@(posedge clk) disable iff (rst)
    (fast_on && en) |=> (fast_on || slow_on));

  // R4
  slow_then_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (slow_on && en) |=> (slow_on || blank_act));

endmodule

bind offtime_chopper offtime_chopper_chk #(.BLANK_CYC(BLANK_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .trip      (trip),
  .drive_on  (drive_on),
  .fast_on   (fast_on),
  .slow_on   (slow_on),
  .blank_act (blank_act)
);

// File: tb/offtime_chopper_bench.sv
module offtime_chopper_bench;

  localparam int OFF_W = 10;
  localparam int BLANK = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, trip = 1'b0, mix_req = 1'b0, auto_mix = 1'b0;
  logic [OFF_W-1:0] off_cycles = '0;
  logic drive_on, fast_on, slow_on, blank_act;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  offtime_chopper #(.OFF_W(OFF_W), .BLANK_CYC(BLANK)) u_offtime_chopper (
    .clk(clk), .rst(rst), .en(en), .trip(trip), .mix_req(mix_req),
    .auto_mix(auto_mix), .off_cycles(off_cycles), .drive_on(drive_on),
    .fast_on(fast_on), .slow_on(slow_on), .blank_act(blank_act)
  );

  // behavioural model: 0 idle, 1 blank, 2 drive, 3 fast, 4 slow
  int ph = 0, left = 0, slow_part = 0;
  always @(posedge clk) begin
    int n, f;
    if (rst) begin
      ph = 0; left = 0;
    end else if (!en) begin
      ph = 0;
    end else begin
      case (ph)
        0: begin ph = 1; left = BLANK; end
        1: begin left--; if (left == 0) ph = 2; end
        2: if (trip) begin
             n = (off_cycles == 0) ? 1 : int'(off_cycles);
             f = (mix_req || auto_mix) ? (n * 5) / 16 : 0;
             slow_part = n - f;
             if (f > 0) begin ph = 3; left = f; end
             else begin ph = 4; left = slow_part; end
           end
        3: begin left--; if (left == 0) begin ph = 4; left = slow_part; end end
        default: begin left--; if (left == 0) begin ph = 1; left = BLANK; end end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  int fast_run = 0, off_run = 0, last_fast = 0, last_off = 0, fast_total = 0;
  always @(posedge clk) begin
    int exp_v, act_v;
    string tag;
    #2;
    exp_v = {29'd0, (ph == 1 || ph == 2), ph == 3, ph == 4} * 2 + ((ph == 1) ? 1 : 0);
    act_v = {29'd0, drive_on, fast_on, slow_on} * 2 + (blank_act ? 1 : 0);
    case (ph)
      0: tag = "R1"; 1: tag = "R2"; 2: tag = "R3"; 3: tag = "R5"; default: tag = "R4";
    endcase
    chk(act_v == exp_v, tag, act_v, exp_v);
    if (fast_on) begin fast_run++; fast_total++; end
    else if (fast_run > 0) begin last_fast = fast_run; fast_run = 0; end
    if (fast_on || slow_on) off_run++;
    else if (off_run > 0) begin last_off = off_run; off_run = 0; end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fire_trip();
    do @(negedge clk); while (!(drive_on && !blank_act));
    trip = 1'b1;
    tick(1);
    trip = 1'b0;
  endtask

  task automatic wait_on();
    do @(negedge clk); while (!drive_on);
    tick(2);
  endtask

  initial begin
    int ft;
    tick(3);
    // R1 reset state
    chk({drive_on, fast_on, slow_on, blank_act} == 4'b0, "R1", {drive_on, fast_on, slow_on, blank_act}, 0);
    rst = 1'b0;
    en = 1'b1;
    tick(1);
    // R2 blanking on turn-on
    chk(drive_on && blank_act, "R2", {drive_on, blank_act}, 3);
    tick(BLANK);
    chk(drive_on && !blank_act, "R2", blank_act, 0);

    // R4 slow decay, N=20
    off_cycles = 20;
    fire_trip(); wait_on();
    chk(last_off == 20, "R4", last_off, 20);

    // R5 mixed, N=32 -> 10 fast
    mix_req = 1'b1; off_cycles = 32;
    fire_trip(); wait_on();
    chk(last_fast == 10, "R5", last_fast, 10);
    chk(last_off == 32, "R5", last_off, 32);

    // R6 strap forces mixed, N=16 -> 5 fast
    mix_req = 1'b0; auto_mix = 1'b1; off_cycles = 16;
    fire_trip(); wait_on();
    chk(last_fast == 5, "R6", last_fast, 5);
    auto_mix = 1'b0;

    // R7 mode and length change mid off-time
    mix_req = 1'b1; off_cycles = 32;
    fire_trip();
    mix_req = 1'b0; off_cycles = 5;
    wait_on();
    chk(last_fast == 10, "R7", last_fast, 10);
    chk(last_off == 32, "R7", last_off, 32);

    // R8 zero length behaves as one
    off_cycles = 0;
    fire_trip(); wait_on();
    chk(last_off == 1, "R8", last_off, 1);

    // R5 N=3 mixed: no fast cycle
    mix_req = 1'b1; off_cycles = 3;
    ft = fast_total;
    fire_trip(); wait_on();
    chk(fast_total == ft, "R5", fast_total - ft, 0);
    chk(last_off == 3, "R5", last_off, 3);

    // R1 enable drop during off-time
    mix_req = 1'b0; off_cycles = 40;
    fire_trip(); tick(3);
    en = 1'b0;
    tick(1);
    chk({drive_on, fast_on, slow_on, blank_act} == 4'b0, "R1", {drive_on, fast_on, slow_on, blank_act}, 0);

    // R3 trip held high through blanking
    trip = 1'b1;
    tick(2);
    en = 1'b1;
    tick(BLANK + 1);
    chk(drive_on && !blank_act, "R3", {drive_on, blank_act}, 2);
    tick(1);
    chk(slow_on, "R3", slow_on, 1);
    trip = 1'b0;
    wait_on();
    tick(5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule